// File: doc/BRIEF.md
# Transaction-Boundary DMA Bus Arbiter

This block decides which of several DMA channels drives a shared memory bus. Each channel holds a request line high while it has work. Alongside the request it gives a width flag: low means an 8-bit transaction of one byte beat, high means a 16-bit transaction of two byte beats. The arbiter picks one channel by fixed priority, with the lowest channel number winning. It holds that grant until the bus side has reported every beat of the transaction through a one-cycle beat-done strobe. Only then does it look at the requests again. A higher-priority request that arrives mid-transaction therefore waits, and a 16-bit transfer is never split.

The request line acts as a valid and the grant as the matching ready. A channel keeps its request high until it has seen its grant, and it may drop the request at any time afterwards. Once a transaction has started it always runs to its last beat. There is no other back-pressure: a granted transaction advances only on beat-done strobes. Grants are also gated by a power-mode input and a debug-halt input. When a sleep request is made, a drained flag rises only once no transaction is in flight and no channel is requesting, so software can wait on that flag before entering sleep.

Top module: `dma_txn_arbiter`

## Requirements
- R1: At most one bit of `grant` is high in any cycle.
- R2: When the bus is free and arbitration is allowed, the lowest-numbered requesting channel gets a one-hot grant on the next clock edge.
- R3: A transaction whose width flag was 0 when it was granted ends on its first accepted beat-done strobe, and `grant` clears on that edge.
- R4: A transaction whose width flag was 1 when it was granted holds its grant through its first accepted beat. It ends on its second accepted beat.
- R5: A request from a higher-priority channel during a transaction does not change `grant` until that transaction ends.
- R6: If the granted channel drops its request mid-transaction, the grant stays until all of that transaction's beats are done.
- R7: While `dbg_halt` is 1, no new grant is issued and beat-done strobes are ignored. The in-flight transaction neither advances nor ends.
- R8: `pwr_mode` values 0 to 3 (active, low-power active, idle, low-power idle) allow new grants. Values 4 (sleep), 5 (suspend), 6 and 7 block new grants. A transaction already in flight still completes.
- R9: `drained` is 1 exactly when `sleep_req` is 1, `busy` is 0 and no request is high.
- R10: `busy` is 1 exactly while a transaction is in flight. After reset, `grant` and `busy` are 0.
- R11: On the edge where a transaction ends, if any request is high and arbitration is allowed, the next winner is granted on that same edge with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | NUM_CH | Per-channel request (valid) |
| wide | input | NUM_CH | Per-channel width flag, 1 = 16-bit (two beats) |
| beat_done | input | 1 | One-cycle strobe from the bus side: one byte beat finished |
| pwr_mode | input | 3 | Power mode code; 0..3 allow grants |
| dbg_halt | input | 1 | Debug halt: stalls grants and beats |
| sleep_req | input | 1 | Request to enter sleep |
| grant | output | NUM_CH | One-hot grant (ready) |
| busy | output | 1 | A transaction is in flight |
| drained | output | 1 | Sleep requested and nothing pending |

## Verification
The arbiter is driven with single requesters, with three simultaneous requesters at spread-out indices, and with a higher-priority request that arrives during a 16-bit transfer. Together these separate correct priority order and a correct beat count from preemption and from splitting a transaction. A request withdrawn mid-transfer and back-to-back transactions show whether the grant follows the beat count or the request lines, and whether a cycle is lost between owners. Each power-mode code, plus debug halt applied both before a grant and during a transaction, shows which gate blocks new grants and which stalls beats. The drain sequence shows that the drained flag waits for the final beat of a 16-bit transfer.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  typedef enum logic [2:0] {
    PM_ACTIVE    = 3'd0,
    PM_LP_ACTIVE = 3'd1,
    PM_IDLE      = 3'd2,
    PM_LP_IDLE   = 3'd3,
    PM_SLEEP     = 3'd4,
    PM_SUSPEND   = 3'd5
  } pwr_mode_e;

  localparam int unsigned BEATS_NARROW = 1;
  localparam int unsigned BEATS_WIDE   = 2;
endpackage

// File: rtl/dma_prio_pick.sv
module dma_prio_pick #(
  parameter int unsigned NUM_CH = 8,
  localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0] req,
  output logic [NUM_CH-1:0] onehot,
  output logic [IDX_W-1:0]  idx,
  output logic              any
);
  logic [NUM_CH:0] lower_seen;
  assign lower_seen[0] = 1'b0;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chain
    assign lower_seen[i+1] = lower_seen[i] | req[i];
    assign onehot[i]       = req[i] & ~lower_seen[i];
  end

  assign any = lower_seen[NUM_CH];

  always_comb begin
    idx = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

  always_comb begin
    assert_pick_onehot_R1: assert ($onehot0(onehot));
    if (any) begin
      assert_pick_matches_R2: assert (onehot[idx] && req[idx]);
    end
  end
endmodule

// File: rtl/dma_beat_counter.sv
module dma_beat_counter #(
  parameter int unsigned MAX_BEATS = dma_arb_pkg::BEATS_WIDE,
  localparam int unsigned CNT_W = (MAX_BEATS > 1) ? $clog2(MAX_BEATS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic load_wide,
  input  logic beat,
  output logic last
);
  logic [CNT_W-1:0] left_q;

  localparam logic [CNT_W-1:0] LEFT_WIDE   = CNT_W'(dma_arb_pkg::BEATS_WIDE - 1);
  localparam logic [CNT_W-1:0] LEFT_NARROW = CNT_W'(dma_arb_pkg::BEATS_NARROW - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q <= '0;
    end else if (load) begin
      left_q <= load_wide ? LEFT_WIDE : LEFT_NARROW;
    end else if (beat && left_q != '0) begin
      left_q <= left_q - 1'b1;
    end
  end

  assign last = (left_q == '0);

  assert_count_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    left_q <= CNT_W'(MAX_BEATS - 1));
  assert_count_steps_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !load && !last) |=> last);
endmodule

// File: rtl/dma_grant_gate.sv
module dma_grant_gate
  import dma_arb_pkg::*;
(
  input  logic [2:0] pwr_mode,
  input  logic       dbg_halt,
  input  logic       beat_in,
  output logic       arb_ok,
  output logic       beat_ok
);
  logic mode_ok;

  always_comb begin
    unique case (pwr_mode)
      PM_ACTIVE, PM_LP_ACTIVE, PM_IDLE, PM_LP_IDLE: mode_ok = 1'b1;
      default:                                       mode_ok = 1'b0;
    endcase
  end

  assign arb_ok  = mode_ok & ~dbg_halt;
  assign beat_ok = beat_in & ~dbg_halt;

  always_comb begin
    if (dbg_halt) begin
      assert_halt_blocks_R7: assert (!arb_ok && !beat_ok);
    end
  end
endmodule

// File: rtl/dma_txn_arbiter.sv
module dma_txn_arbiter #(
  parameter int unsigned NUM_CH = 8,
  localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] req,
  input  logic [NUM_CH-1:0] wide,
  input  logic              beat_done,
  input  logic [2:0]        pwr_mode,
  input  logic              dbg_halt,
  input  logic              sleep_req,
  output logic [NUM_CH-1:0] grant,
  output logic              busy,
  output logic              drained
);
  logic [NUM_CH-1:0] pick_oh;
  logic [IDX_W-1:0]  pick_idx;
  logic              pick_any;
  logic              arb_ok;
  logic              beat_ok;
  logic              last_beat;
  logic              txn_end;
  logic              start;
  logic [NUM_CH-1:0] grant_q;
  logic              active_q;

  dma_prio_pick #(.NUM_CH(NUM_CH)) u_pick (
    .req    (req),
    .onehot (pick_oh),
    .idx    (pick_idx),
    .any    (pick_any)
  );

  dma_grant_gate u_gate (
    .pwr_mode (pwr_mode),
    .dbg_halt (dbg_halt),
    .beat_in  (beat_done & active_q),
    .arb_ok   (arb_ok),
    .beat_ok  (beat_ok)
  );

  dma_beat_counter #(.MAX_BEATS(dma_arb_pkg::BEATS_WIDE)) u_beats (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start),
    .load_wide (wide[pick_idx]),
    .beat      (beat_ok),
    .last      (last_beat)
  );

  assign txn_end = beat_ok & last_beat;
  assign start   = arb_ok & pick_any & (~active_q | txn_end);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q  <= '0;
      active_q <= 1'b0;
    end else if (start) begin
      grant_q  <= pick_oh;
      active_q <= 1'b1;
    end else if (txn_end) begin
      grant_q  <= '0;
      active_q <= 1'b0;
    end
  end

  assign grant   = grant_q;
  assign busy    = active_q;
  assign drained = sleep_req & ~active_q & ~pick_any;

  assert_grant_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));
  assert_busy_matches_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (grant != '0));
  assert_no_preempt_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !beat_done) |=> $stable(grant));
  assert_halt_freezes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_halt |=> $stable(grant));
  assert_mode_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && pwr_mode > 3'd3) |=> !busy);
  assert_drained_clean_R9: assert property (@(posedge clk) disable iff (!rst_n)
    drained |-> (!busy && req == '0 && sleep_req));
endmodule

// File: tb/dma_txn_arbiter_tb_top.sv
module dma_txn_arbiter_tb_top;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] req = '0;
  logic [N-1:0] wide = '0;
  logic         beat_done = 1'b0;
  logic [2:0]   pwr_mode = 3'd0;
  logic         dbg_halt = 1'b0;
  logic         sleep_req = 1'b0;
  logic [N-1:0] grant;
  logic         busy;
  logic         drained;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  dma_txn_arbiter #(.NUM_CH(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .wide(wide), .beat_done(beat_done),
    .pwr_mode(pwr_mode), .dbg_halt(dbg_halt), .sleep_req(sleep_req),
    .grant(grant), .busy(busy), .drained(drained)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic beat();
    beat_done = 1'b1;
    step();
    beat_done = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 reset grant", grant, 0);
    chk("R10 reset busy", busy, 0);
    chk("R9 reset drained", drained, 0);
  endtask

  task automatic t_single_narrow();
    req[3] = 1'b1;
    step();
    chk("R2 single grant", grant, 8'h08);
    chk("R10 busy in flight", busy, 1);
    req[3] = 1'b0;
    beat();
    chk("R3 narrow ends after one beat", grant, 0);
    chk("R10 busy clears", busy, 0);
  endtask

  task automatic t_priority();
    req = 8'b1010_0100;
    step();
    chk("R2 lowest index wins", grant, 8'h04);
    req[2] = 1'b0;
    beat();
    chk("R11 back-to-back to ch5", grant, 8'h20);
    chk("R1 single owner", $countones(grant), 1);
    req[5] = 1'b0;
    beat();
    chk("R11 back-to-back to ch7", grant, 8'h80);
    req[7] = 1'b0;
    beat();
    chk("R3 last narrow ends", grant, 0);
  endtask

  task automatic t_wide_no_preempt();
    wide[6] = 1'b1;
    req[6] = 1'b1;
    step();
    chk("R2 grant ch6", grant, 8'h40);
    req[1] = 1'b1;
    beat();
    chk("R4 wide holds after beat one", grant, 8'h40);
    chk("R5 no preemption by ch1", grant, 8'h40);
    req[6] = 1'b0;
    beat();
    chk("R11 ch1 follows wide end", grant, 8'h02);
    req[1] = 1'b0;
    beat();
    chk("R3 ch1 ends", grant, 0);
    wide[6] = 1'b0;
  endtask

  task automatic t_drop_mid();
    wide[4] = 1'b1;
    req[4] = 1'b1;
    step();
    chk("R2 grant ch4", grant, 8'h10);
    req[4] = 1'b0;
    step();
    chk("R6 grant kept after drop", grant, 8'h10);
    beat();
    chk("R6 grant kept until second beat", grant, 8'h10);
    beat();
    chk("R4 wide ends after two beats", grant, 0);
    wide[4] = 1'b0;
  endtask

  task automatic t_debug();
    dbg_halt = 1'b1;
    req[0] = 1'b1;
    step();
    step();
    chk("R7 no grant under halt", grant, 0);
    dbg_halt = 1'b0;
    step();
    chk("R7 grant after halt clears", grant, 8'h01);
    dbg_halt = 1'b1;
    req[0] = 1'b0;
    beat();
    chk("R7 beat ignored under halt", grant, 8'h01);
    dbg_halt = 1'b0;
    beat();
    chk("R7 beat accepted after halt", grant, 0);
  endtask

  task automatic t_modes();
    for (int m = 4; m < 8; m++) begin
      pwr_mode = 3'(m);
      req[2] = 1'b1;
      step();
      step();
      chk($sformatf("R8 mode %0d blocks", m), busy, 0);
    end
    for (int m = 0; m < 4; m++) begin
      pwr_mode = 3'(m);
      step();
      chk($sformatf("R8 mode %0d grants", m), grant, 8'h04);
      pwr_mode = 3'd5;
      req[2] = 1'b0;
      beat();
      chk("R8 in-flight completes in suspend", busy, 0);
      req[2] = 1'b1;
    end
    req[2] = 1'b0;
    pwr_mode = 3'd0;
  endtask

  task automatic t_drain();
    wide[5] = 1'b1;
    req[5] = 1'b1;
    sleep_req = 1'b1;
    #1;
    chk("R9 not drained with request", drained, 0);
    step();
    chk("R9 not drained while granted", drained, 0);
    req[5] = 1'b0;
    beat();
    chk("R9 not drained mid wide", drained, 0);
    beat();
    chk("R9 drained after last beat", drained, 1);
    sleep_req = 1'b0;
    #1;
    chk("R9 drained needs sleep_req", drained, 0);
    wide[5] = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_narrow();
    t_priority();
    t_wide_no_preempt();
    t_drop_mid();
    t_debug();
    t_modes();
    t_drain();
    step();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule